// File: doc/BRIEF.md
# Serial DMA Grant Decoder

This block sits on the PCI clock and watches a single active-low grant line driven by an upstream bus arbiter. The line idles high. When the arbiter grants the bus to a legacy DMA channel, it sends a short frame. The frame is one cycle of low level as a start marker, then three cycles that carry the channel number. The decoder recognises the marker and shifts in the channel code. It then presents a one-hot acknowledge for the selected channel, the channel number, and a one-cycle valid pulse.

Channel 4 is never granted, so its code is reserved. A frame that carries the reserved code raises a one-cycle error flag instead of a grant. A grant that has been accepted stays in force until the DMA logic signals end of transfer or reset is applied. While a grant is held, the decoder does not react to activity on the grant line.

Top module: `dma_grant_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `dack_o`, `gnt_valid_o`, `code_err_o` and `chan_o` all zero.
- R2: A frame starts only when `gnt_n_i` is sampled low while the decoder is idle and holds no grant. A line held high produces no output activity.
- R3: The three samples after the start marker form the channel code, most significant bit first. A sampled high level on `gnt_n_i` is a 1 and a low level is a 0.
- R4: Codes 0, 1, 2, 3, 5, 6 and 7 select the channel with the same number. After the frame, `dack_o[n]` is the only high acknowledge bit for channel n, and `chan_o` equals n.
- R5: `gnt_valid_o` is high for exactly one cycle, in the cycle directly after the edge that samples the last code bit. `dack_o` and `chan_o` take their new values in that same cycle.
- R6: Code 4 is reserved. It raises `code_err_o` for exactly one cycle in the cycle after the last code bit. It leaves `dack_o` zero and `gnt_valid_o` low, and it returns the decoder to idle, ready for the next frame.
- R7: A granted acknowledge keeps its value until `eot_i` is sampled high or reset is applied.
- R8: A start marker that arrives while a grant is held is ignored. It causes no valid pulse and no change to `dack_o` or `chan_o`.
- R9: Sampling `eot_i` high while a grant is held clears `dack_o` in the following cycle. After that, a new frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gnt_n_i | input | 1 | Serial grant line from the arbiter, active low, idles high |
| eot_i | input | 1 | End of transfer; releases the held grant |
| dack_o | output | 8 | One-hot DMA acknowledge, active high, bit n for channel n |
| gnt_valid_o | output | 1 | One-cycle pulse when a new grant is decoded |
| chan_o | output | 3 | Number of the most recently granted channel |
| code_err_o | output | 1 | One-cycle pulse when the reserved code is received |

## Verification
The assertions check these properties on every cycle:
- at most one acknowledge bit is high;
- valid and error never pulse together and each lasts only one cycle;
- every valid pulse follows a low start marker four cycles earlier and points at a non-reserved channel that is acknowledged;
- a held grant stays stable until end of transfer, which clears it.

Only the bench scenarios can show the following:
- that each code maps to the right channel, bit order included;
- that the reserved code leaves the decoder ready for another frame;
- that markers sent during a held grant are really dropped.

// File: rtl/dgr_pkg.sv
// Package: shared types for the serial DMA grant decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package dgr_pkg;

    // Frame receiver states.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } frame_st_e;

endpackage

// File: rtl/dgr_frame_rx.sv
// Module: dgr_frame_rx
// Detects the start marker on the serial grant line and shifts in the
// channel code MSB first. It raises frame_done_o combinationally on the
// cycle in which the last code bit is on the line; code_o is then the
// complete code.
// Assumes: line idles high; accept_i is low while a grant is held, so
// markers in that time are dropped.
module dgr_frame_rx #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              accept_i,
    output logic              frame_done_o,
    output logic [CODE_W-1:0] code_o
);
    import dgr_pkg::*;

    localparam int CNT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CODE_W - 1);

    frame_st_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-2:0] shreg_q;

    // Last code bit is being sampled this cycle.
    assign frame_done_o = (state_q == ST_SHIFT) && (cnt_q == LAST_CNT);
    // Full code: earlier bits from the shift register, newest from the line.
    assign code_o       = {shreg_q, line_i};

    // Frame state, bit counter and code shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (accept_i && !line_i) begin
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (frame_done_o) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        shreg_q <= code_o[CODE_W-2:0];
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dgr_code_dec.sv
// Module: dgr_code_dec
// Turns a binary channel code into a one-hot acknowledge vector and
// flags the reserved code, which maps to no acknowledge.
// Assumes: NUM_CH is a power of two equal to 2**CODE_W.
module dgr_code_dec #(
    parameter int NUM_CH   = 8,
    parameter int CODE_W   = 3,
    parameter int RSV_CODE = 4
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [NUM_CH-1:0] onehot_o,
    output logic              rsv_o
);

    // Reserved code detect.
    assign rsv_o = (code_i == CODE_W'(RSV_CODE));

    // One decode term per channel; the reserved channel is tied low.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        if (ch == RSV_CODE) begin : g_rsv
            assign onehot_o[ch] = 1'b0;
        end else begin : g_use
            assign onehot_o[ch] = (code_i == CODE_W'(ch));
        end
    end

endmodule

// File: rtl/dgr_grant_hold.sv
// Module: dgr_grant_hold
// Holds the acknowledge vector and channel number after a good frame.
// It also produces the one-cycle valid pulse and the one-cycle reserved
// code error pulse.
// Assumes: frame_done_i only rises while no grant is held, so a load and
// an end-of-transfer clear never meet on a held grant.
module dgr_grant_hold #(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [NUM_CH-1:0] onehot_i,
    input  logic              rsv_i,
    input  logic              eot_i,
    output logic [NUM_CH-1:0] dack_o,
    output logic              valid_o,
    output logic              err_o,
    output logic [CODE_W-1:0] chan_o,
    output logic              held_o
);

    // Any acknowledge bit high means a grant is in force.
    assign held_o = |dack_o;

    // Grant register, pulse flags and channel number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dack_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            chan_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (eot_i) begin
                dack_o <= '0;
            end
            if (frame_done_i) begin
                if (rsv_i) begin
                    err_o <= 1'b1;
                end else begin
                    dack_o  <= onehot_i;
                    chan_o  <= code_i;
                    valid_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dma_grant_rx.sv
// Module: dma_grant_rx (top)
// Serial DMA grant decoder. Receives a start marker plus a three-bit
// channel code on an active-low line and presents a held one-hot
// acknowledge. The reserved code produces an error pulse instead.
// Assumes: synchronous active-low reset on the PCI clock; the line is
// already synchronous to clk.
module dma_grant_rx #(
    parameter int NUM_CH   = 8,
    parameter int RSV_CODE = 4,
    localparam int CODE_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_n_i,
    input  logic              eot_i,
    output logic [NUM_CH-1:0] dack_o,
    output logic              gnt_valid_o,
    output logic [CODE_W-1:0] chan_o,
    output logic              code_err_o
);

    logic              frame_done;
    logic [CODE_W-1:0] code;
    logic [NUM_CH-1:0] onehot;
    logic              rsv;
    logic              held;

    dgr_frame_rx #(.CODE_W(CODE_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (gnt_n_i),
        .accept_i     (!held),
        .frame_done_o (frame_done),
        .code_o       (code)
    );

    dgr_code_dec #(
        .NUM_CH   (NUM_CH),
        .CODE_W   (CODE_W),
        .RSV_CODE (RSV_CODE)
    ) u_dec (
        .code_i   (code),
        .onehot_o (onehot),
        .rsv_o    (rsv)
    );

    dgr_grant_hold #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W)
    ) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done_i (frame_done),
        .code_i       (code),
        .onehot_i     (onehot),
        .rsv_i        (rsv),
        .eot_i        (eot_i),
        .dack_o       (dack_o),
        .valid_o      (gnt_valid_o),
        .err_o        (code_err_o),
        .chan_o       (chan_o),
        .held_o       (held)
    );

endmodule

// File: rtl/dgr_chk.sv
// Module: dgr_chk
// Assertion checker for dma_grant_rx, attached by bind below.
// Assumes: observes top-level ports only.
module dgr_chk #(
    parameter int NUM_CH   = 8,
    parameter int RSV_CODE = 4,
    localparam int CODE_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gnt_n_i,
    input logic              eot_i,
    input logic [NUM_CH-1:0] dack_o,
    input logic              gnt_valid_o,
    input logic [CODE_W-1:0] chan_o,
    input logic              code_err_o
);

    // R4
    dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack_o));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |=> !gnt_valid_o);

    // R5
    valid_after_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> !$past(gnt_n_i, 4));

    // R4
    valid_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> (dack_o[chan_o] && chan_o != CODE_W'(RSV_CODE)));

    // R6
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |=> !code_err_o);

    // R6
    err_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |-> (!gnt_valid_o && dack_o == '0));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dack_o != '0 && !eot_i) |=> ($stable(dack_o) && $stable(chan_o)));

    // R9
    eot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_i && dack_o != '0) |=> (dack_o == '0));

endmodule

bind dma_grant_rx dgr_chk #(
    .NUM_CH   (NUM_CH),
    .RSV_CODE (RSV_CODE)
) u_dgr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gnt_n_i     (gnt_n_i),
    .eot_i       (eot_i),
    .dack_o      (dack_o),
    .gnt_valid_o (gnt_valid_o),
    .chan_o      (chan_o),
    .code_err_o  (code_err_o)
);

// File: tb/test_dma_grant_rx.sv
// Directed bench for dma_grant_rx. Inputs change and outputs are sampled
// on the falling edge of a 50 MHz clock.
module test_dma_grant_rx;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       gnt_n_i;
    logic       eot_i;
    logic [7:0] dack_o;
    logic       gnt_valid_o;
    logic [2:0] chan_o;
    logic       code_err_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_grant_rx i_dma_grant_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .gnt_n_i     (gnt_n_i),
        .eot_i       (eot_i),
        .dack_o      (dack_o),
        .gnt_valid_o (gnt_valid_o),
        .chan_o      (chan_o),
        .code_err_o  (code_err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Send marker and three code bits, MSB first; returns after the edge
    // that sampled the last bit, line back high.
    task automatic send_frame(input logic [2:0] code);
        gnt_n_i = 1'b0;
        for (int b = 2; b >= 0; b--) begin
            @(negedge clk);
            gnt_n_i = code[b];
        end
        @(negedge clk);
        gnt_n_i = 1'b1;
    endtask

    task automatic release_grant();
        eot_i = 1'b1;
        @(negedge clk);
        eot_i = 1'b0;
        // R9: cleared one cycle after eot sampled
        chk("R9 dack clear", int'(dack_o), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; gnt_n_i = 1'b1; eot_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 dack", int'(dack_o), 0);
        chk("R1 valid", int'(gnt_valid_o), 0);
        chk("R1 err", int'(code_err_o), 0);
        chk("R1 chan", int'(chan_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        repeat (6) begin
            @(negedge clk);
            // R2: line high gives nothing
            chk("R2 idle valid", int'(gnt_valid_o), 0);
            chk("R2 idle dack", int'(dack_o), 0);
        end
    endtask

    task automatic t_channel(input int ch);
        send_frame(3'(ch));
        // R5, R4, R3
        chk("R5 valid", int'(gnt_valid_o), 1);
        chk("R4 dack", int'(dack_o), 1 << ch);
        chk("R3 chan", int'(chan_o), ch);
        chk("R6 no err", int'(code_err_o), 0);
        repeat (3) @(negedge clk);
        // R5 pulse over; R7 still held
        chk("R5 single pulse", int'(gnt_valid_o), 0);
        chk("R7 held", int'(dack_o), 1 << ch);
        release_grant();
    endtask

    task automatic t_reserved();
        send_frame(3'd4);
        // R6
        chk("R6 err", int'(code_err_o), 1);
        chk("R6 no valid", int'(gnt_valid_o), 0);
        chk("R6 no dack", int'(dack_o), 0);
        @(negedge clk);
        chk("R6 err single", int'(code_err_o), 0);
        // R6: back to idle, next frame accepted
        send_frame(3'd6);
        chk("R6 recover valid", int'(gnt_valid_o), 1);
        chk("R6 recover dack", int'(dack_o), 1 << 6);
        release_grant();
    endtask

    task automatic t_ignore();
        send_frame(3'd2);
        chk("R4 dack ch2", int'(dack_o), 1 << 2);
        @(negedge clk);
        send_frame(3'd6);
        // R8
        chk("R8 no valid", int'(gnt_valid_o), 0);
        chk("R8 dack kept", int'(dack_o), 1 << 2);
        chk("R8 chan kept", int'(chan_o), 2);
        @(negedge clk);
        chk("R8 still kept", int'(dack_o), 1 << 2);
        release_grant();
        // R9: new frame accepted after release
        send_frame(3'd7);
        chk("R9 new grant", int'(dack_o), 1 << 7);
        chk("R9 new chan", int'(chan_o), 7);
        release_grant();
    endtask

    task automatic t_reset_clears();
        send_frame(3'd1);
        chk("R4 dack ch1", int'(dack_o), 1 << 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R1, R7: reset drops the held grant
        chk("R7 reset clears", int'(dack_o), 0);
        chk("R1 chan after reset", int'(chan_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        for (int ch = 0; ch < 8; ch++) begin
            if (ch != 4) t_channel(ch);
        end
        t_reserved();
        t_ignore();
        t_reset_clears();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule